// File: doc/BRIEF.md
# ADC Channel Scan Sequencer

This block holds the control logic for an eight-input successive-approximation converter. It has one control register and one data register. The converter itself sits outside the block. The sequencer tells it which input to sample with a one-cycle start pulse and a channel number. It also gives the converter a clock-enable tick and a power enable. When the converter reports completion, the block latches the result together with the number of the channel that was converted. It then raises a completion flag, and an overrun flag if the previous result had not been read yet.

A conversion can begin in one of three ways:
- A single conversion started at once by software.
- A conversion started by a real edge on one of six trigger inputs, with the active edge chosen by software.
- A free-running burst that steps through the selected inputs from the lowest upward and wraps around.

Any write to the control register takes effect on the very next conversion. All fields written in the same cycle are used together. A write that lands while a conversion is running cancels that conversion, marks completion and then starts again under the new settings.

Top module: `adc_scan_seq`

## Requirements
- R1: After reset, `data_done`, `data_overrun`, `data_result`, `data_chan`, `conv_start` and `conv_pwr` are all zero.
- R2: Control field layout is: select mask in bits 7:0, divider in bits 15:8, burst in bit 16, power-up in bit 21, start code in bits 26:24, falling-edge select in bit 27. Writing start code 001 with burst clear starts one conversion of the lowest selected channel. `data_result` and `data_chan` then show that conversion and `data_done` rises.
- R3: In burst mode, conversions cover every selected channel from the lowest upward and then wrap. The first conversion after the write uses the mask written in that same cycle.
- R4: A select mask of all zeros is treated as channel 0 only, in every start mode.
- R5: Writing the control register with burst clear ends the repeated conversions. After the aborted conversion is reported, no further result arrives.
- R6: Start codes 010 to 111 select trigger input `trig_in[code-2]`. Falling-edge select 0 starts on a rising edge and 1 on a falling edge. The inputs are synchronised through two flops. A level already present when the code is written starts nothing, and edges on unselected inputs start nothing.
- R7: While the power-up bit is clear or `pd_global` is high, `conv_pwr` is low, `conv_tick` stays low and no conversion starts or completes.
- R8: A control write during a running conversion ends that conversion and sets `data_done` on the next clock edge. A conversion under the newly written settings then starts if those settings call for one.
- R9: Pulsing `rd_en` clears `data_done` and `data_overrun`. A completion that arrives while `data_done` is still set also sets `data_overrun`.
- R10: While powered, `conv_tick` pulses once every divider+1 clock cycles.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| cfg_we | input | 1 | Control register write strobe |
| cfg_wdata | input | 32 | Control register write value |
| rd_en | input | 1 | Data register read strobe (clears flags) |
| pd_global | input | 1 | Chip-wide power-down request |
| trig_in | input | 6 | Asynchronous conversion trigger inputs |
| conv_pwr | output | 1 | Converter power enable |
| conv_tick | output | 1 | Converter clock-enable pulse |
| conv_start | output | 1 | One-cycle conversion start |
| conv_chan | output | 3 | Channel to convert |
| conv_done | input | 1 | Converter completion pulse |
| conv_result | input | 10 | Converter result, valid with `conv_done` |
| data_result | output | 10 | Last stored result |
| data_chan | output | 3 | Channel of the last stored result |
| data_done | output | 1 | Completion flag |
| data_overrun | output | 1 | Result overwritten before it was read |

## Verification
The assertions take for granted that the converter raises `conv_done` only for a conversion it was actually started on. They also assume the pulse arrives in a later cycle than the start pulse. Finally, they assume `rd_en` and `cfg_we` are single-cycle strobes driven away from the clock edge. The bench converter model restarts on every start pulse, stops while power is off, and reports after a fixed number of ticks, so every completion belongs to a started conversion. Trigger inputs are moved only at falling clock edges and held for several cycles, so every edge passes cleanly through the synchroniser.

// File: rtl/adc_seq_pkg.sv
package adc_seq_pkg;
    localparam int NCH   = 8;
    localparam int CHW   = $clog2(NCH);
    localparam int DIVW  = 8;
    localparam int RW    = 10;
    localparam int NTRIG = 6;

    localparam logic [2:0] START_NONE = 3'd0;
    localparam logic [2:0] START_NOW  = 3'd1;
    localparam logic [2:0] START_TRIG0 = 3'd2;

    typedef struct packed {
        logic [2:0]      start;
        logic            fall;
        logic            pwr;
        logic            burst;
        logic [DIVW-1:0] div;
        logic [NCH-1:0]  sel;
    } ctrl_t;

    function automatic ctrl_t decode_ctrl(input logic [31:0] w);
        ctrl_t c;
        c.sel   = w[NCH-1:0];
        c.div   = w[15:8];
        c.burst = w[16];
        c.pwr   = w[21];
        c.start = w[26:24];
        c.fall  = w[27];
        return c;
    endfunction
endpackage

// File: rtl/adc_chan_pick.sv
module adc_chan_pick #(
    parameter int NCH = 8,
    parameter int CHW = $clog2(NCH)
) (
    input  logic [NCH-1:0] mask,
    input  logic [CHW-1:0] cur,
    output logic [CHW-1:0] first_ch,
    output logic [CHW-1:0] next_ch
);
    // Scanning downward lets the lowest match win; an empty mask yields 0.
    always_comb begin
        first_ch = '0;
        for (int i = NCH - 1; i >= 0; i--) begin
            if (mask[i]) first_ch = CHW'(i);
        end
    end

    always_comb begin
        next_ch = first_ch;
        for (int i = NCH - 1; i >= 0; i--) begin
            if (mask[i] && (i > int'(cur))) next_ch = CHW'(i);
        end
    end
endmodule

// File: rtl/adc_trig_edge.sv
module adc_trig_edge #(
    parameter int NTRIG = 6
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic [NTRIG-1:0] raw,
    input  logic             fall,
    output logic [NTRIG-1:0] hit
);
    logic [NTRIG-1:0] s1_q, s2_q, prev_q;

    for (genvar g = 0; g < NTRIG; g++) begin : g_trig
        always_ff @(posedge clk or negedge rst_n) begin
            if (!rst_n) begin
                s1_q[g]   <= 1'b0;
                s2_q[g]   <= 1'b0;
                prev_q[g] <= 1'b0;
            end else begin
                s1_q[g]   <= raw[g];
                s2_q[g]   <= s1_q[g];
                prev_q[g] <= s2_q[g];
            end
        end
        assign hit[g] = fall ? (prev_q[g] & ~s2_q[g]) : (~prev_q[g] & s2_q[g]);

        // R6: a detected edge needs a level change two flops back
        p_edge_synced_r6: assert property (@(posedge clk) disable iff (!rst_n)
            hit[g] |-> $past(s1_q[g]) != prev_q[g]);
    end
endmodule

// File: rtl/adc_tick_div.sv
module adc_tick_div #(
    parameter int DIVW = 8
) (
    input  logic            clk,
    input  logic            rst_n,
    input  logic            en,
    input  logic [DIVW-1:0] div,
    output logic            tick
);
    typedef struct packed {
        logic [DIVW-1:0] cnt;
        logic            tick;
    } div_st_t;

    div_st_t st_d, st_q;

    always_comb begin
        st_d = st_q;
        st_d.tick = 1'b0;
        if (!en) begin
            st_d.cnt = '0;
        end else if (st_q.cnt >= div) begin
            st_d.cnt  = '0;
            st_d.tick = 1'b1;
        end else begin
            st_d.cnt = st_q.cnt + 1'b1;
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) st_q <= '0;
        else        st_q <= st_d;
    end

    assign tick = st_q.tick;

    p_tick_gap_r10: assert property (@(posedge clk) disable iff (!rst_n)
        (tick && div != '0) |=> (!tick || div == '0));
    p_tick_off_r7: assert property (@(posedge clk) disable iff (!rst_n)
        !en |=> !tick);
endmodule

// File: rtl/adc_scan_seq.sv
module adc_scan_seq
    import adc_seq_pkg::*;
#(
    parameter int P_NCH   = NCH,
    parameter int P_CHW   = CHW,
    parameter int P_NTRIG = NTRIG,
    parameter int P_RW    = RW
) (
    input  logic               clk,
    input  logic               rst_n,
    input  logic               cfg_we,
    input  logic [31:0]        cfg_wdata,
    input  logic               rd_en,
    input  logic               pd_global,
    input  logic [P_NTRIG-1:0] trig_in,
    output logic               conv_pwr,
    output logic               conv_tick,
    output logic               conv_start,
    output logic [P_CHW-1:0]   conv_chan,
    input  logic               conv_done,
    input  logic [P_RW-1:0]    conv_result,
    output logic [P_RW-1:0]    data_result,
    output logic [P_CHW-1:0]   data_chan,
    output logic               data_done,
    output logic               data_overrun
);
    typedef struct packed {
        ctrl_t            cfg;
        logic             busy;
        logic [P_CHW-1:0] chan;
        logic             start;
        logic [P_RW-1:0]  res;
        logic [P_CHW-1:0] res_chan;
        logic             done;
        logic             ovr;
    } seq_st_t;

    seq_st_t st_d, st_q;
    ctrl_t   cfg_n;
    logic [P_CHW-1:0]   first_ch, next_ch;
    logic [P_NTRIG-1:0] hits;
    logic fin, abrt, idle, go, pwr_n, trig_hit;
    logic [P_CHW-1:0] pick;

    assign cfg_n = cfg_we ? decode_ctrl(cfg_wdata) : st_q.cfg;

    adc_chan_pick #(.NCH(P_NCH), .CHW(P_CHW)) u_pick (
        .mask(cfg_n.sel), .cur(st_q.chan), .first_ch(first_ch), .next_ch(next_ch)
    );

    adc_trig_edge #(.NTRIG(P_NTRIG)) u_trig (
        .clk(clk), .rst_n(rst_n), .raw(trig_in), .fall(cfg_n.fall), .hit(hits)
    );

    adc_tick_div #(.DIVW(DIVW)) u_div (
        .clk(clk), .rst_n(rst_n), .en(conv_pwr), .div(st_q.cfg.div), .tick(conv_tick)
    );

    always_comb begin
        trig_hit = 1'b0;
        for (int i = 0; i < P_NTRIG; i++) begin
            if (cfg_n.start == 3'(i + 2)) trig_hit = hits[i];
        end
    end

    always_comb begin
        st_d       = st_q;
        st_d.cfg   = cfg_n;
        st_d.start = 1'b0;
        pwr_n      = cfg_n.pwr & ~pd_global;
        fin        = st_q.busy & conv_done & ~cfg_we;
        abrt       = st_q.busy & cfg_we;

        if (rd_en) begin
            st_d.done = 1'b0;
            st_d.ovr  = 1'b0;
        end
        if (fin) begin
            st_d.res      = conv_result;
            st_d.res_chan = st_q.chan;
        end
        if (fin || abrt) begin
            if (st_q.done && !rd_en) st_d.ovr = 1'b1;
            st_d.done = 1'b1;
            st_d.busy = 1'b0;
        end
        idle = ~st_q.busy | fin | abrt;

        go   = 1'b0;
        pick = first_ch;
        if (cfg_n.burst) begin
            go   = idle;
            pick = fin ? next_ch : first_ch;
        end else if (cfg_we && cfg_n.start == START_NOW) begin
            go = 1'b1;
        end else if (cfg_n.start >= START_TRIG0) begin
            go = idle & trig_hit;
        end

        if (!pwr_n) begin
            go        = 1'b0;
            st_d.busy = 1'b0;
        end
        if (go) begin
            st_d.busy  = 1'b1;
            st_d.chan  = pick;
            st_d.start = 1'b1;
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) st_q <= '0;
        else        st_q <= st_d;
    end

    assign conv_pwr     = st_q.cfg.pwr & ~pd_global;
    assign conv_start   = st_q.start;
    assign conv_chan    = st_q.chan;
    assign data_result  = st_q.res;
    assign data_chan    = st_q.res_chan;
    assign data_done    = st_q.done;
    assign data_overrun = st_q.ovr;

    p_no_start_pd_r7: assert property (@(posedge clk) disable iff (!rst_n)
        $past(pd_global) |-> !conv_start);
    p_chan_in_mask_r3: assert property (@(posedge clk) disable iff (!rst_n)
        (conv_start && st_q.cfg.sel != '0) |-> st_q.cfg.sel[conv_chan]);
    p_zero_mask_r4: assert property (@(posedge clk) disable iff (!rst_n)
        (conv_start && st_q.cfg.sel == '0) |-> conv_chan == '0);
    p_read_clears_r9: assert property (@(posedge clk) disable iff (!rst_n)
        (rd_en && !cfg_we && !conv_done) |=> !data_done);
    p_ovr_needs_done_r9: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(data_overrun) |-> $past(data_done));
    p_abort_done_r8: assert property (@(posedge clk) disable iff (!rst_n)
        (cfg_we && st_q.busy) |=> data_done);
endmodule

// File: tb/adc_scan_seq_test.sv
module adc_scan_seq_test;
    localparam int CT = 4;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        cfg_we = 1'b0;
    logic [31:0] cfg_wdata = '0;
    logic        rd_en = 1'b0;
    logic        pd_global = 1'b0;
    logic [5:0]  trig_in = '0;
    logic        conv_pwr, conv_tick, conv_start, conv_done;
    logic [2:0]  conv_chan, data_chan;
    logic [9:0]  conv_result, data_result;
    logic        data_done, data_overrun;

    int nvec = 0;
    int nerr = 0;

    always #4 clk = ~clk;

    adc_scan_seq uut (
        .clk(clk), .rst_n(rst_n), .cfg_we(cfg_we), .cfg_wdata(cfg_wdata),
        .rd_en(rd_en), .pd_global(pd_global), .trig_in(trig_in),
        .conv_pwr(conv_pwr), .conv_tick(conv_tick), .conv_start(conv_start),
        .conv_chan(conv_chan), .conv_done(conv_done), .conv_result(conv_result),
        .data_result(data_result), .data_chan(data_chan),
        .data_done(data_done), .data_overrun(data_overrun)
    );

    // Behavioural converter: CT ticks per conversion, restarts on each start.
    logic       m_run;
    logic [3:0] m_cnt;
    logic [2:0] m_ch;
    always @(posedge clk) begin
        if (!rst_n || !conv_pwr) begin
            m_run <= 1'b0; conv_done <= 1'b0; m_cnt <= '0; m_ch <= '0;
        end else begin
            conv_done <= 1'b0;
            if (conv_start) begin
                m_run <= 1'b1; m_cnt <= '0; m_ch <= conv_chan;
            end else if (m_run && conv_tick) begin
                if (m_cnt == CT - 1) begin
                    m_run <= 1'b0; conv_done <= 1'b1;
                end else m_cnt <= m_cnt + 1'b1;
            end
        end
    end
    assign conv_result = {m_ch, 7'(m_ch * 13 + 5)};

    function automatic logic [9:0] exp_res(input logic [2:0] c);
        return {c, 7'(c * 13 + 5)};
    endfunction

    function automatic logic [31:0] mk(input logic [7:0] sel, input logic [7:0] dv,
            input logic burst, input logic pwr, input logic [2:0] st, input logic fall);
        return {4'b0, fall, st, 2'b0, pwr, 4'b0, burst, dv, sel};
    endfunction

    task automatic chk(input string req, input int act, input int exp);
        nvec++;
        if (act != exp) begin
            nerr++;
            $display("FAIL %s actual %0d expected %0d", req, act, exp);
        end
    endtask

    task automatic wr(input logic [31:0] v);
        @(negedge clk); cfg_we = 1'b1; cfg_wdata = v;
        @(negedge clk); cfg_we = 1'b0;
    endtask

    task automatic rd();
        @(negedge clk); rd_en = 1'b1;
        @(negedge clk); rd_en = 1'b0;
    endtask

    task automatic wait_done(input int max, output bit ok);
        ok = 1'b0;
        for (int i = 0; i < max; i++) begin
            @(negedge clk);
            if (data_done) begin ok = 1'b1; break; end
        end
    endtask

    task automatic idle_n(input int n);
        repeat (n) @(negedge clk);
    endtask

    // Vectors: {mask, expected channel} for single software starts.
    localparam int NV = 7;
    localparam logic [10:0] VEC [NV] = '{
        {8'h01, 3'd0}, {8'h80, 3'd7}, {8'h0C, 3'd2}, {8'h28, 3'd3},
        {8'hF0, 3'd4}, {8'h41, 3'd0}, {8'h00, 3'd0}
    };

    initial begin
        #(8 * 150000);
        nvec++; nerr++;
        $display("FAIL watchdog: actual timeout expected completion");
        $display("== %0d vectors applied, %0d miscompares ==", nvec, nerr);
        $finish;
    end

    initial begin
        bit ok;
        int gap;
        logic [2:0] seq [5];

        idle_n(3);
        chk("R1 done", int'(data_done), 0);
        chk("R1 overrun", int'(data_overrun), 0);
        chk("R1 result", int'(data_result), 0);
        chk("R1 pwr", int'(conv_pwr), 0);
        chk("R1 start", int'(conv_start), 0);
        rst_n = 1'b1;
        idle_n(2);

        // R2 / R4: single software starts from the vector table
        for (int v = 0; v < NV; v++) begin
            wr(mk(VEC[v][10:3], 8'd1, 1'b0, 1'b1, 3'd1, 1'b0));
            wait_done(100, ok);
            chk("R2 done", int'(ok), 1);
            chk(VEC[v][10:3] == 8'h00 ? "R4 chan" : "R2 chan", int'(data_chan), int'(VEC[v][2:0]));
            chk("R2 result", int'(data_result), int'(exp_res(VEC[v][2:0])));
            rd();
            chk("R9 read clears", int'(data_done), 0);
        end

        // R10: tick period with divider 3
        wr(mk(8'h01, 8'd3, 1'b0, 1'b1, 3'd0, 1'b0));
        for (int i = 0; i < 20; i++) begin @(negedge clk); if (conv_tick) break; end
        gap = 0;
        for (int i = 0; i < 20; i++) begin @(negedge clk); gap++; if (conv_tick) break; end
        chk("R10 tick period", gap, 4);

        // R3: burst over channels 2,5,7; previous mask held channel 0
        wr(mk(8'hA4, 8'd1, 1'b1, 1'b1, 3'd0, 1'b0));
        for (int k = 0; k < 5; k++) begin
            wait_done(100, ok);
            seq[k] = data_chan;
            rd();
        end
        chk("R3 first", int'(seq[0]), 2);
        chk("R3 second", int'(seq[1]), 5);
        chk("R3 third", int'(seq[2]), 7);
        chk("R3 wrap", int'(seq[3]), 2);
        chk("R3 after wrap", int'(seq[4]), 5);

        // R5: stop the burst
        wr(mk(8'hA4, 8'd1, 1'b0, 1'b1, 3'd0, 1'b0));
        chk("R8 stop sets done", int'(data_done), 1);
        rd();
        idle_n(60);
        chk("R5 no more results", int'(data_done), 0);

        // R4: empty mask burst converts channel 0 repeatedly
        wr(mk(8'h00, 8'd1, 1'b1, 1'b1, 3'd0, 1'b0));
        wait_done(100, ok); chk("R4 burst chan a", int'(data_chan), 0); rd();
        wait_done(100, ok); chk("R4 burst chan b", int'(data_chan), 0);
        chk("R4 burst result", int'(data_result), int'(exp_res(3'd0)));
        wr(mk(8'h00, 8'd1, 1'b0, 1'b1, 3'd0, 1'b0));
        rd(); idle_n(40); rd();

        // R8: write during a slow conversion
        wr(mk(8'h08, 8'd10, 1'b0, 1'b1, 3'd1, 1'b0));
        idle_n(6);
        chk("R8 still running", int'(data_done), 0);
        wr(mk(8'h40, 8'd1, 1'b0, 1'b1, 3'd1, 1'b0));
        chk("R8 abort done", int'(data_done), 1);
        rd();
        wait_done(30, ok);
        chk("R8 restarted", int'(ok), 1);
        chk("R8 new chan", int'(data_chan), 6);
        rd();

        // R9: overrun
        wr(mk(8'h02, 8'd1, 1'b0, 1'b1, 3'd1, 1'b0));
        wait_done(100, ok);
        wr(mk(8'h10, 8'd1, 1'b0, 1'b1, 3'd1, 1'b0));
        idle_n(30);
        chk("R9 overrun set", int'(data_overrun), 1);
        chk("R9 newest chan", int'(data_chan), 4);
        rd();
        chk("R9 overrun cleared", int'(data_overrun), 0);
        chk("R9 done cleared", int'(data_done), 0);

        // R6: rising edge on trig_in[2] (code 4); level present at write
        trig_in[2] = 1'b1; idle_n(5);
        wr(mk(8'h02, 8'd1, 1'b0, 1'b1, 3'd4, 1'b0));
        idle_n(30);
        chk("R6 level ignored", int'(data_done), 0);
        trig_in[0] = 1'b1; idle_n(5); trig_in[0] = 1'b0; idle_n(30);
        chk("R6 other input ignored", int'(data_done), 0);
        trig_in[2] = 1'b0; idle_n(30);
        chk("R6 wrong edge ignored", int'(data_done), 0);
        trig_in[2] = 1'b1;
        wait_done(40, ok);
        chk("R6 rising starts", int'(ok), 1);
        chk("R6 chan", int'(data_chan), 1);
        rd();
        // falling edge select, input currently low after a fall
        trig_in[2] = 1'b0; idle_n(5);
        wr(mk(8'h02, 8'd1, 1'b0, 1'b1, 3'd4, 1'b1));
        idle_n(30);
        chk("R6 low level ignored", int'(data_done), 0);
        trig_in[2] = 1'b1; idle_n(30);
        chk("R6 rise ignored in fall mode", int'(data_done), 0);
        trig_in[2] = 1'b0;
        wait_done(40, ok);
        chk("R6 falling starts", int'(ok), 1);
        rd();
        wr(mk(8'h02, 8'd1, 1'b0, 1'b1, 3'd0, 1'b0));

        // R7: power-up bit clear
        wr(mk(8'h01, 8'd1, 1'b0, 1'b0, 3'd1, 1'b0));
        idle_n(40);
        chk("R7 bit clear no result", int'(data_done), 0);
        chk("R7 bit clear pwr", int'(conv_pwr), 0);
        // R7: global power-down overrides
        pd_global = 1'b1;
        wr(mk(8'h20, 8'd1, 1'b1, 1'b1, 3'd0, 1'b0));
        idle_n(40);
        chk("R7 pd no result", int'(data_done), 0);
        chk("R7 pd pwr", int'(conv_pwr), 0);
        chk("R7 pd tick", int'(conv_tick), 0);
        pd_global = 1'b0;
        wait_done(100, ok);
        chk("R7 resumes", int'(ok), 1);
        chk("R7 resume chan", int'(data_chan), 5);
        wr(mk(8'h20, 8'd1, 1'b0, 1'b1, 3'd0, 1'b0));
        rd();

        $display("== %0d vectors applied, %0d miscompares ==", nvec, nerr);
        $finish;
    end
endmodule